// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

The block collects 64 level-sensitive interrupt sources and drives two request lines toward a processor: a fast line and a normal line. Each source carries an enable bit, a type bit choosing the fast or the normal line, and a 4-bit priority. Software reaches the state through a 32-bit, word-addressed register file. It can enable or disable sources one at a time by writing a source number, or rewrite whole enable and type halves. It can overwrite pending state through force registers. It takes interrupts by reading a vector register, and that read acknowledges the returned source.

The normal line is gated by a 5-bit mask. A source is taken only when its priority exceeds the mask, except that the all-ones mask value lets any normal pending source through. The normal vector read picks the highest priority, and on a tie the highest source number. The fast vector read picks the lowest-numbered fast source. The priority search sits in a separate combinational arbiter.

Top module: `vic_regs`

## Requirements
- R1: A source's pending bit is loaded from its input level only in the cycle after that level changes. Between changes the bit keeps whatever a force write or an acknowledge left in it. Within one edge, a level change is applied first, then a force write, then an acknowledge clear.
- R2: Word offsets 4/5 read and write the enable vector bits 63:32/31:0, and 6/7 do the same for the type vector (1 = fast). Offsets 8 to 15 hold the priorities: offset k carries sources 8*(15-k) to 8*(15-k)+7, with source 8*(15-k)+j in bits 4j+3:4j.
- R3: A write to offset 2 sets, and a write to offset 3 clears, the enable bit selected by data bits 5:0. All other data bits are ignored. Both offsets read as zero.
- R4: Offset 0 stores only data bits 24, 22, 21, 20, 19 and 18, so it reads back as the written value AND 0x017C0000.
- R5: After reset the mask at offset 1 (bits 4:0) reads 0x1F, and every other register and both outputs read zero.
- R6: The fast output is high exactly when some source is pending, enabled and typed fast.
- R7: The normal output is high when some source is pending, enabled and typed normal, and either the mask equals 0x1F or that source's priority is greater than the mask.
- R8: A read of offset 16 returns the source number in bits 21:16 and its priority in bits 3:0. The source is the normal pending one with the highest priority, the highest number winning a tie. The read clears that pending bit at the next edge. With no normal pending source the read returns 0xFFFFFFFF and changes nothing.
- R9: A read of offset 17 returns the lowest-numbered fast pending source number and clears its pending bit at the next edge. With none, it returns 0xFFFFFFFF.
- R10: A write to offset 20/21 replaces pending bits 63:32/31:0. Offsets 20/21 read as zero, and offsets 18/19 return raw pending bits 63:32/31:0.
- R11: Offsets 22/23 read the normal pending view (pending, enabled, not fast) and 24/25 the fast pending view, as high/low halves.
- R12: Writes to offsets 16 to 19 and 22 to 25, to the vector window 64 to 191, and to any unmapped offset change no state. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 64 | Source request levels |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The embedded assertions check several properties on every cycle. The reset value of the mask must hold. Single enable bits must follow number writes. A normal vector read must return a source that is normal pending, together with that source's own priority nibble. A fast vector read must return the lowest pending fast source. The normal line must stay low with nothing normal pending. Other behaviour can only be shown by the bench's scenarios. These include the tie-break between equal priorities, the all-ones mask bypass and priority gating against the mask, and an acknowledged source staying cleared until its level changes again. They also include force writes replacing a half of the pending vector, the control write mask, and the ignored writes to read-only, vector-window and unmapped offsets.

// File: rtl/vic_prio_arb.sv
module vic_prio_arb #(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    found,
  output logic [IDX_W-1:0]        win_idx,
  output logic [PRIO_W-1:0]       win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] >= win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4,
  parameter int MASK_W = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int IDX_W      = $clog2(N_SRC);
  localparam int PER_WORD   = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = N_SRC / PER_WORD;
  localparam int HALF       = N_SRC / 2;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h017C_0000;
  localparam logic [DATA_W-1:0] NONE      = '1;

  localparam logic [ADDR_W-1:0] A_CTRL = 0, A_MASK = 1, A_ENNUM = 2, A_DISNUM = 3;
  localparam logic [ADDR_W-1:0] A_EN_HI = 4, A_EN_LO = 5, A_TY_HI = 6, A_TY_LO = 7;
  localparam int                PRIO_BASE = 8;
  localparam logic [ADDR_W-1:0] A_NVEC = 16, A_FVEC = 17, A_ST_HI = 18, A_ST_LO = 19;
  localparam logic [ADDR_W-1:0] A_FO_HI = 20, A_FO_LO = 21, A_NP_HI = 22, A_NP_LO = 23;
  localparam logic [ADDR_W-1:0] A_FP_HI = 24, A_FP_LO = 25;

  logic [N_SRC-1:0]        src_q, pending, enabled, fast_ty, pend_nx;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [DATA_W-1:0]       ctrl_q;
  logic [MASK_W-1:0]       nmask;

  wire wr = bus_valid &&  bus_write;
  wire rd = bus_valid && !bus_write;

  wire [N_SRC-1:0] norm_pend = pending & enabled & ~fast_ty;
  wire [N_SRC-1:0] fast_pend = pending & enabled &  fast_ty;

  logic              n_found, f_found;
  logic [IDX_W-1:0]  n_idx, f_idx;
  logic [PRIO_W-1:0] n_prio;

  vic_prio_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req(norm_pend), .prio_flat(prio_flat),
    .found(n_found), .win_idx(n_idx), .win_prio(n_prio)
  );

  always_comb begin
    f_found = 1'b0;
    f_idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (fast_pend[i]) begin
        f_found = 1'b1;
        f_idx   = IDX_W'(i);
      end
    end
  end

  logic above;
  always_comb begin
    above = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (norm_pend[i] && MASK_W'(prio_flat[i*PRIO_W +: PRIO_W]) > nmask) above = 1'b1;
  end

  assign fiq_out = |fast_pend;
  assign irq_out = (|norm_pend) && (&nmask || above);

  wire [DATA_W-1:0] nvec = n_found ?
    {{(DATA_W/2-IDX_W){1'b0}}, n_idx, {(DATA_W/2-PRIO_W){1'b0}}, n_prio} : NONE;
  wire [DATA_W-1:0] fvec = f_found ? {{(DATA_W-IDX_W){1'b0}}, f_idx} : NONE;

  logic [DATA_W-1:0] prio_rd;
  always_comb begin
    prio_rd = '0;
    for (int w = 0; w < PRIO_WORDS; w++)
      if (bus_addr == ADDR_W'(PRIO_BASE + w))
        prio_rd = prio_flat[(PRIO_WORDS-1-w)*DATA_W +: DATA_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_q;
        A_MASK:  bus_rdata = DATA_W'(nmask);
        A_EN_HI: bus_rdata = enabled[N_SRC-1:HALF];
        A_EN_LO: bus_rdata = enabled[HALF-1:0];
        A_TY_HI: bus_rdata = fast_ty[N_SRC-1:HALF];
        A_TY_LO: bus_rdata = fast_ty[HALF-1:0];
        A_NVEC:  bus_rdata = nvec;
        A_FVEC:  bus_rdata = fvec;
        A_ST_HI: bus_rdata = pending[N_SRC-1:HALF];
        A_ST_LO: bus_rdata = pending[HALF-1:0];
        A_NP_HI: bus_rdata = norm_pend[N_SRC-1:HALF];
        A_NP_LO: bus_rdata = norm_pend[HALF-1:0];
        A_FP_HI: bus_rdata = fast_pend[N_SRC-1:HALF];
        A_FP_LO: bus_rdata = fast_pend[HALF-1:0];
        default: bus_rdata = prio_rd;
      endcase
    end
  end

  always_comb begin
    pend_nx = (pending & ~(src_lvl ^ src_q)) | (src_lvl & (src_lvl ^ src_q));
    if (wr && bus_addr == A_FO_HI) pend_nx[N_SRC-1:HALF] = bus_wdata;
    if (wr && bus_addr == A_FO_LO) pend_nx[HALF-1:0]     = bus_wdata;
    if (rd && bus_addr == A_NVEC && n_found) pend_nx[n_idx] = 1'b0;
    if (rd && bus_addr == A_FVEC && f_found) pend_nx[f_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= '0;
      pending   <= '0;
      enabled   <= '0;
      fast_ty   <= '0;
      prio_flat <= '0;
      ctrl_q    <= '0;
      nmask     <= '1;
    end else begin
      src_q   <= src_lvl;
      pending <= pend_nx;
      if (wr) begin
        case (bus_addr)
          A_CTRL:   ctrl_q <= bus_wdata & CTRL_KEEP;
          A_MASK:   nmask  <= bus_wdata[MASK_W-1:0];
          A_ENNUM:  enabled[bus_wdata[IDX_W-1:0]] <= 1'b1;
          A_DISNUM: enabled[bus_wdata[IDX_W-1:0]] <= 1'b0;
          A_EN_HI:  enabled[N_SRC-1:HALF] <= bus_wdata;
          A_EN_LO:  enabled[HALF-1:0]     <= bus_wdata;
          A_TY_HI:  fast_ty[N_SRC-1:HALF] <= bus_wdata;
          A_TY_LO:  fast_ty[HALF-1:0]     <= bus_wdata;
          default: ;
        endcase
        for (int w = 0; w < PRIO_WORDS; w++)
          if (bus_addr == ADDR_W'(PRIO_BASE + w))
            prio_flat[(PRIO_WORDS-1-w)*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  assert_mask_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> nmask == '1);

  assert_enable_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_ENNUM) |=> enabled[$past(bus_wdata[IDX_W-1:0])]);

  assert_disable_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_DISNUM) |=> !enabled[$past(bus_wdata[IDX_W-1:0])]);

  assert_nvec_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_NVEC && bus_rdata != NONE) |->
      (norm_pend[bus_rdata[16 +: IDX_W]] &&
       prio_flat[bus_rdata[16 +: IDX_W]*PRIO_W +: PRIO_W] == bus_rdata[PRIO_W-1:0]));

  assert_fvec_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_FVEC && bus_rdata != NONE) |->
      (fast_pend[bus_rdata[IDX_W-1:0]] &&
       (fast_pend & ((N_SRC'(1) << bus_rdata[IDX_W-1:0]) - N_SRC'(1))) == '0));

  assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    norm_pend == '0 |-> !irq_out);
endmodule

// File: tb/vic_regs_test.sv
module vic_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [63:0] src_lvl = '0;
  logic        bus_valid = 0, bus_write = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  vic_regs uut (.clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd_chk(string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, $sformatf("read offset %0d", a), d, exp);
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk);
    src_lvl[i] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R5", "irq after reset", 32'(irq_out), 0);
    check("R5", "fiq after reset", 32'(fiq_out), 0);
    rd_chk("R5", 1, 32'h1f);
    rd_chk("R5", 0, 0);
    rd_chk("R5", 5, 0);
    rd_chk("R5", 19, 0);
  endtask

  task automatic t_control;
    wr(0, 32'hffff_ffff);
    rd_chk("R4", 0, 32'h017c_0000);
    wr(0, 32'h0200_0000);
    rd_chk("R4", 0, 0);
  endtask

  task automatic t_enable_num;
    wr(2, 32'h45);
    rd_chk("R3", 5, 32'h20);
    rd_chk("R3", 2, 0);
    wr(2, 32'h3f);
    rd_chk("R3", 4, 32'h8000_0000);
    wr(3, 32'hc5);
    rd_chk("R3", 5, 0);
    rd_chk("R3", 3, 0);
    wr(4, 0);
  endtask

  task automatic t_layout;
    wr(6, 32'ha5a5_0000);
    rd_chk("R2", 6, 32'ha5a5_0000);
    wr(7, 32'h1234);
    rd_chk("R2", 7, 32'h1234);
    wr(15, 32'h8765_4321);
    rd_chk("R2", 15, 32'h8765_4321);
    rd_chk("R2", 8, 0);
    wr(6, 0); wr(7, 0); wr(15, 0);
  endtask

  task automatic t_irq;
    wr(5, 32'hffff_ffff); wr(4, 32'hffff_ffff);
    set_src(3, 1);
    rd_chk("R11", 23, 32'h8);
    check("R7", "irq with mask 0x1f bypass", 32'(irq_out), 1);
    wr(1, 0);
    check("R7", "irq prio 0 not above mask 0", 32'(irq_out), 0);
    wr(15, 32'h5000);
    check("R7", "irq prio 5 above mask 0", 32'(irq_out), 1);
    wr(1, 5);
    check("R7", "irq prio 5 equal mask 5", 32'(irq_out), 0);
    wr(1, 4);
    check("R7", "irq prio 5 above mask 4", 32'(irq_out), 1);
  endtask

  task automatic t_nvec;
    set_src(10, 1);
    wr(14, 32'h500);
    rd_chk("R8", 16, 32'h000a_0005);
    rd_chk("R8", 19, 32'h8);
    rd_chk("R8", 16, 32'h0003_0005);
    rd_chk("R8", 16, 32'hffff_ffff);
    check("R8", "irq after both taken", 32'(irq_out), 0);
    set_src(3, 0); set_src(10, 0);
  endtask

  task automatic t_fiq;
    wr(6, 32'h102);
    set_src(33, 1); set_src(40, 1);
    check("R6", "fiq with fast pending", 32'(fiq_out), 1);
    check("R7", "irq with only fast pending", 32'(irq_out), 0);
    rd_chk("R11", 24, 32'h102);
    rd_chk("R11", 22, 0);
    rd_chk("R9", 17, 33);
    rd_chk("R9", 17, 40);
    rd_chk("R9", 17, 32'hffff_ffff);
    check("R6", "fiq after acknowledges", 32'(fiq_out), 0);
    set_src(33, 0);
    rd_chk("R1", 18, 0);
    set_src(33, 1);
    check("R1", "fiq after level rises again", 32'(fiq_out), 1);
    rd_chk("R1", 18, 32'h2);
    set_src(33, 0); set_src(40, 0);
    wr(6, 0);
  endtask

  task automatic t_force;
    wr(21, 32'h8000_0001);
    rd_chk("R10", 19, 32'h8000_0001);
    rd_chk("R10", 21, 0);
    wr(20, 32'h1);
    rd_chk("R10", 18, 32'h1);
    check("R7", "irq forced prio 0 under mask 4", 32'(irq_out), 0);
    wr(1, 32'h1f);
    check("R7", "irq forced with bypass mask", 32'(irq_out), 1);
    wr(21, 0); wr(20, 0);
    check("R10", "irq after force clear", 32'(irq_out), 0);
  endtask

  task automatic t_ignored;
    wr(18, 32'hffff_ffff); wr(19, 32'hffff_ffff);
    wr(16, 32'hffff_ffff); wr(17, 32'hffff_ffff);
    wr(23, 32'hffff_ffff); wr(25, 32'hffff_ffff);
    rd_chk("R12", 19, 0);
    rd_chk("R12", 18, 0);
    wr(64, 32'h0); wr(191, 32'h0); wr(30, 32'h0);
    rd_chk("R12", 5, 32'hffff_ffff);
    rd_chk("R12", 1, 32'h1f);
    rd_chk("R12", 30, 0);
    rd_chk("R12", 64, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_control();
    t_enable_num();
    t_layout();
    t_irq();
    t_nvec();
    t_fiq();
    t_force();
    t_ignored();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule